// File: doc/BRIEF.md
# Dual-Clock FIFO with Latched Threshold Flags

This block is a first-in, first-out buffer with a write side and a read side that run on independent clocks. Words enter on rising write-clock edges and leave through a registered output on rising read-clock edges. Every status flag belongs to the clock domain of the port that acts on it. The empty and almost-empty flags are produced in the read domain. The full and almost-full flags are produced in the write domain. All four flags are active low.

Each pointer crosses into the other domain as a Gray code through a two-stage synchronizer. Because of this, a flag reacts to an operation on the opposite port only after two rising edges of its own clock. A flag reacts to an operation on its own port at once.

The almost-empty and almost-full flags share one threshold X. A two-bit select input is captured while reset is asserted and picks X from four presets. X then stays fixed until the next reset.

Top module: `dc_fifo_flags`

## Requirements
- R1: While reset is asserted and right after it is released, empty_n = 0, aempty_n = 0, full_n = 1 and afull_n = 1, and both pointers point at the first location.
- R2: A read request seen on a rising rclk edge while empty_n = 1 loads the oldest stored word into dout. Words come out in the order they were accepted. dout holds its value in every other cycle.
- R3: A read request made while empty_n = 0 is ignored. dout does not change, and the next word written is still the next word read.
- R4: full_n drops on the write edge that stores the word filling all DEPTH (64) locations. A write request made while full_n = 0 is ignored and does not change the stored contents.
- R5: After a write into an empty FIFO, empty_n is still 0 after the first following rclk rising edge. It is 1 after the third following rclk rising edge at the latest.
- R6: After a read from a full FIFO, full_n is still 0 after the first following wclk rising edge. It is 1 after the third following wclk rising edge at the latest.
- R7: Once the flags have settled, aempty_n = 0 when the FIFO holds X or fewer words, and aempty_n = 1 when it holds X+1 or more.
- R8: Once the flags have settled, afull_n = 0 when the FIFO holds DEPTH−X or more words, and afull_n = 1 when it holds fewer.
- R9: X is chosen by ofs_sel while rst_n = 0: 0 gives 16, 1 gives 12, 2 gives 8 and 3 gives 4 (for DEPTH 64, each step is DEPTH/16). Changing ofs_sel after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ofs_sel | input | 2 | Threshold preset select, captured during reset |
| wclk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| din | input | DW (36) | Write data |
| full_n | output | 1 | Low when no location is free (wclk domain) |
| afull_n | output | 1 | Low when fill is at least DEPTH−X (wclk domain) |
| rclk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| dout | output | DW (36) | Registered read data |
| empty_n | output | 1 | Low when no word is available (rclk domain) |
| aempty_n | output | 1 | Low when fill is X or less (rclk domain) |

## Verification
The bench uses the default DW = 36 and AW = 6. With these values a 64-word fill is cheap, so the full boundary, ignored writes and the recovery latency after a read can all be driven directly. The bench resets with three different ofs_sel values (X = 16, 12 and 4) and alters ofs_sel after reset each time. This puts the almost-empty edge at X/X+1 and the almost-full edge at DEPTH−X−1/DEPTH−X on both sides for several thresholds. The write and read clocks use periods of 10 and 13 ns, so the latency checks see edges arriving at many different phase offsets.

// File: rtl/dc_fifo_flags.sv
module dc_fifo_flags #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          rst_n,
  input  logic [1:0]    ofs_sel,
  input  logic          wclk,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rclk,
  input  logic          rd_en,
  output logic [DW-1:0] dout,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] STEP    = PW'(DEPTH / 16);

  function automatic logic [PW-1:0] preset(input logic [1:0] s);
    return (PW'(4) - PW'(s)) * STEP;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wgray, rq1, rq2, xw;
  logic [PW-1:0] rbin, rgray, wq1, wq2, xr;
  logic [PW-1:0] wcount, rcount;
  logic          wr_ok, rd_ok;

  assign wr_ok  = wr_en & full_n;
  assign rd_ok  = rd_en & empty_n;
  assign wcount = wbin - g2b(rq2);
  assign rcount = g2b(wq2) - rbin;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
      xw    <= preset(ofs_sel);
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_ok) begin
        wbin  <= wbin + PW'(1);
        wgray <= b2g(wbin + PW'(1));
      end
    end
  end

  always_ff @(posedge wclk)
    if (wr_ok) mem[wbin[AW-1:0]] <= din;

  assign full_n  = wgray != {~rq2[PW-1:PW-2], rq2[PW-3:0]};
  assign afull_n = wcount < (DEPTH_P - xw);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
      xr    <= preset(ofs_sel);
      dout  <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_ok) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rbin + PW'(1);
        rgray <= b2g(rbin + PW'(1));
      end
    end
  end

  assign empty_n  = rgray != wq2;
  assign aempty_n = rcount > xr;

  // R4
  wr_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_P);

  // R3
  rd_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    rcount <= DEPTH_P);

  // R2
  dout_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_en && empty_n) |=> $stable(dout));

  // R7
  aempty_vs_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    aempty_n |-> empty_n);

  // R8
  full_vs_afull_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R9
  ofs_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $stable(xw));
endmodule

// File: tb/tb_dc_fifo_flags.sv
module tb_dc_fifo_flags;
  localparam int WCLK_P = 10;
  localparam int RCLK_P = 13;
  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic          rst_n = 1'b0;
  logic [1:0]    ofs_sel = 2'd0;
  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          full_n, afull_n, empty_n, aempty_n;

  int n_chk = 0, n_fail = 0;
  int seed = 1;
  logic [DW-1:0] q[$];

  dc_fifo_flags #(.DW(DW), .AW(6)) dut (
    .rst_n(rst_n), .ofs_sel(ofs_sel),
    .wclk(wclk), .wr_en(wr_en), .din(din), .full_n(full_n), .afull_n(afull_n),
    .rclk(rclk), .rd_en(rd_en), .dout(dout), .empty_n(empty_n), .aempty_n(aempty_n));

  always #(WCLK_P/2) wclk = ~wclk;
  always #(RCLK_P/2.0) rclk = ~rclk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] next_word();
    seed = seed * 1103515245 + 12345;
    return {4'(seed >> 3), 32'(seed) ^ 32'h5A5A_0F0F};
  endfunction

  task automatic do_reset(input logic [1:0] s, input logic [1:0] after);
    rst_n = 1'b0; ofs_sel = s; wr_en = 1'b0; rd_en = 1'b0;
    q.delete();
    #(5*WCLK_P);
    @(negedge wclk) rst_n = 1'b1;
    #1 ofs_sel = after;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; din = d;
    if (full_n) q.push_back(d);
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop();
    logic ok_rd;
    logic [DW-1:0] prev, exp;
    @(negedge rclk);
    rd_en = 1'b1; ok_rd = empty_n; prev = dout;
    @(negedge rclk);
    rd_en = 1'b0;
    if (ok_rd) begin
      exp = q.pop_front();
      check(dout == exp, "R2 order", 64'(dout), 64'(exp));
    end else begin
      check(dout == prev, "R3 read ignored", 64'(dout), 64'(prev));
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
  endtask

  task automatic drain();
    while (q.size() > 0) pop();
    settle();
    check(empty_n == 1'b0, "R2 empty after drain", 64'(empty_n), 64'd0);
  endtask

  task automatic t_reset_state();
    check(empty_n == 1'b0, "R1 empty_n", 64'(empty_n), 64'd0);
    check(aempty_n == 1'b0, "R1 aempty_n", 64'(aempty_n), 64'd0);
    check(full_n == 1'b1, "R1 full_n", 64'(full_n), 64'd1);
    check(afull_n == 1'b1, "R1 afull_n", 64'(afull_n), 64'd1);
  endtask

  task automatic t_empty_latency();
    logic [DW-1:0] d;
    d = next_word();
    @(negedge wclk);
    wr_en = 1'b1; din = d;
    @(posedge wclk);
    #1 wr_en = 1'b0;
    q.push_back(d);
    @(posedge rclk); #1;
    check(empty_n == 1'b0, "R5 still empty after 1 edge", 64'(empty_n), 64'd0);
    repeat (2) @(posedge rclk);
    #1;
    check(empty_n == 1'b1, "R5 not empty by 3rd edge", 64'(empty_n), 64'd1);
    pop();
    @(negedge rclk);
    check(empty_n == 1'b0, "R2 empty after last read", 64'(empty_n), 64'd0);
  endtask

  task automatic t_read_empty();
    logic [DW-1:0] d;
    pop();
    pop();
    check(empty_n == 1'b0, "R3 stays empty", 64'(empty_n), 64'd0);
    d = next_word();
    push(d);
    settle();
    pop();
  endtask

  task automatic t_order();
    for (int i = 0; i < 10; i++) push(next_word());
    settle();
    drain();
  endtask

  task automatic t_almost_empty(input int x);
    for (int i = 0; i < x; i++) push(next_word());
    settle();
    check(aempty_n == 1'b0, "R7 fill X gives low", 64'(aempty_n), 64'd0);
    push(next_word());
    settle();
    check(aempty_n == 1'b1, "R7 fill X+1 gives high", 64'(aempty_n), 64'd1);
    pop();
    settle();
    check(aempty_n == 1'b0, "R7 back to X gives low", 64'(aempty_n), 64'd0);
    drain();
  endtask

  task automatic t_full(input int x);
    logic [DW-1:0] exp;
    for (int i = 0; i < DEPTH - x - 1; i++) push(next_word());
    settle();
    check(afull_n == 1'b1, "R8 below threshold high", 64'(afull_n), 64'd1);
    push(next_word());
    settle();
    check(afull_n == 1'b0, "R8 at threshold low", 64'(afull_n), 64'd0);
    while (q.size() < DEPTH - 1) push(next_word());
    check(full_n == 1'b1, "R4 not full at 63", 64'(full_n), 64'd1);
    push(next_word());
    check(full_n == 1'b0, "R4 full at 64", 64'(full_n), 64'd0);
    for (int i = 0; i < 3; i++) push(next_word());
    check(q.size() == DEPTH, "R4 writes ignored", 64'(q.size()), 64'(DEPTH));
    settle();
    @(negedge rclk);
    rd_en = 1'b1;
    @(posedge rclk);
    #1 rd_en = 1'b0;
    exp = q.pop_front();
    @(posedge wclk); #1;
    check(full_n == 1'b0, "R6 still full after 1 edge", 64'(full_n), 64'd0);
    repeat (2) @(posedge wclk);
    #1;
    check(full_n == 1'b1, "R6 not full by 3rd edge", 64'(full_n), 64'd1);
    check(dout == exp, "R2 first word after full", 64'(dout), 64'(exp));
    drain();
  endtask

  initial begin
    #(200000 * WCLK_P);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(2'd0, 2'd3);
    t_reset_state();
    t_empty_latency();
    t_read_empty();
    t_order();
    t_almost_empty(16);
    t_full(16);
    // R9 preset 3 -> X=4, select changed after reset
    do_reset(2'd3, 2'd0);
    t_reset_state();
    t_almost_empty(4);
    t_full(4);
    // R9 preset 1 -> X=12
    do_reset(2'd1, 2'd2);
    t_almost_empty(12);
    t_full(12);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule